// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Storage Access Controller

This block connects a small CPU core to a private byte-addressable storage array that behaves like EEPROM. The array is its own data space of 512 bytes. Software reaches it only through four registers on a simple I/O bus: two address registers that together hold a 9-bit byte address, a data register and a control register. Every access moves exactly one byte.

A read strobe copies the addressed byte into the data register and holds the CPU stall output for four cycles. A write only takes effect after an arming step. Software sets the arm bit, and a write strobe must follow within a short window of cycles. An accepted write holds the CPU stall for two cycles. It then keeps a busy flag set for a parameterised number of cycles, which models the self-timed programming of the cell. Software can poll the busy flag, or it can enable a level-sensitive ready interrupt that is high whenever the controller is idle.

Top module: `nvm_ctrl`

## Requirements
- R1: Register offsets on `io_addr` are 0 for address bits 7:0, 1 for address bit 8 (in bit 0), 2 for data and 3 for control. A written address value reads back unchanged, and each access moves exactly one byte at that 9-bit address.
- R2: Writing control with bit 0 (read strobe) set, bit 1 clear and the controller idle loads the data register with the addressed byte. The next data register read returns that byte.
- R3: An accepted read strobe holds `cpu_stall` high for exactly four cycles, starting in the cycle after the strobe.
- R4: An accepted write strobe holds `cpu_stall` high for exactly two cycles, starting in the cycle after the strobe.
- R5: Writing control with bit 2 (arm) set opens a window of four cycles. Control bit 2 reads as 1 during the window and clears by itself when the window ends. A write strobe (control bit 1) on any of the four clock edges that follow the arm write is accepted.
- R6: A write strobe with no arm window open, including one on the fifth edge after arming, is ignored. The array is unchanged, busy stays 0 and `cpu_stall` stays low.
- R7: An accepted write stores the data register at the current address. Control bit 4 (busy) then reads as 1 for `WR_CYCLES` cycles, starting in the cycle after the strobe.
- R8: While busy, write strobes and read strobes are ignored. The data register keeps its value, the array is unchanged, and the busy time is not extended.
- R9: `rdy_irq` is high exactly when control bit 3 (interrupt enable) is set and the controller is not busy.
- R10: Reset clears the control bits, busy, the arm window, the stall and the address register, and it leaves the array contents intact.
- R11: An accepted write strobe closes the arm window, so control bit 2 reads 0 right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_we | input | 1 | Register write enable |
| io_re | input | 1 | Register read enable; `io_rdata` is valid in the next cycle |
| io_addr | input | 2 | Register offset |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Registered read data |
| cpu_stall | output | 1 | Holds the CPU after an access |
| rdy_irq | output | 1 | Level ready interrupt request |

## Verification
The assertions check on every cycle that accepted reads and writes load the stall length that belongs to them. They also check that busy only rises after an open arm window, that an unarmed strobe never starts busy, that busy cannot be extended, that the interrupt is quiet while busy, and that reset leaves the controller idle. Other behaviours can only be shown by the bench's scenarios: the byte values that travel through the array at the extreme addresses, the exact edges where the arm window opens and closes, the data register staying stable under a read strobe while busy, and the array surviving a reset.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  // register offsets on the I/O bus
  localparam int REG_ADDR_LO = 0;
  localparam int REG_ADDR_HI = 1;
  localparam int REG_DATA    = 2;
  localparam int REG_CTRL    = 3;
  // control register bit positions
  localparam int CB_RD   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_ARM  = 2;
  localparam int CB_IE   = 3;
  localparam int CB_BUSY = 4;
endpackage

// File: rtl/nvm_down_timer.sv
module nvm_down_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         clr,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         active
);
  assign active = (count != '0);

  always_ff @(posedge clk) begin
    if (rst)         count <= '0;
    else if (load)   count <= load_val;
    else if (clr)    count <= '0;
    else if (active) count <= count - 1'b1;
  end
endmodule

// File: rtl/nvm_byte_array.sv
module nvm_byte_array #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  // no reset: contents persist across controller reset
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl #(
  parameter int DEPTH     = 512,
  parameter int WR_CYCLES = 16,
  parameter int RD_STALL  = 4,
  parameter int WR_STALL  = 2,
  parameter int ARM_WIN   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       io_we,
  input  logic       io_re,
  input  logic [1:0] io_addr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       cpu_stall,
  output logic       rdy_irq
);
  import nvm_pkg::*;

  localparam int AW        = $clog2(DEPTH);
  localparam int HI_W      = AW - 8;
  localparam int STALL_MAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int SW        = $clog2(STALL_MAX + 1);
  localparam int BW        = $clog2(WR_CYCLES + 1);
  localparam int ARW       = $clog2(ARM_WIN + 1);

  logic [AW-1:0]  addr_q;
  logic [7:0]     data_q;
  logic           ie_q;
  logic           rd_pend_q;
  logic [7:0]     mem_q;
  logic           ctrl_wr, wr_go, rd_go;
  logic           busy, arm_active, stall_active;
  logic [BW-1:0]  busy_cnt;
  logic [SW-1:0]  stall_cnt;
  logic [ARW-1:0] arm_cnt;

  assign ctrl_wr = io_we && (io_addr == 2'(REG_CTRL));
  assign wr_go   = ctrl_wr && io_wdata[CB_WR] && arm_active && !busy;
  assign rd_go   = ctrl_wr && io_wdata[CB_RD] && !io_wdata[CB_WR] && !busy;

  nvm_down_timer #(.W(ARW)) u_arm (
    .clk(clk), .rst(rst),
    .load(ctrl_wr && io_wdata[CB_ARM]), .clr(wr_go),
    .load_val(ARW'(ARM_WIN)), .count(arm_cnt), .active(arm_active)
  );

  nvm_down_timer #(.W(BW)) u_busy (
    .clk(clk), .rst(rst), .load(wr_go), .clr(1'b0),
    .load_val(BW'(WR_CYCLES)), .count(busy_cnt), .active(busy)
  );

  nvm_down_timer #(.W(SW)) u_stall (
    .clk(clk), .rst(rst), .load(wr_go || rd_go), .clr(1'b0),
    .load_val(wr_go ? SW'(WR_STALL) : SW'(RD_STALL)),
    .count(stall_cnt), .active(stall_active)
  );

  nvm_byte_array #(.DEPTH(DEPTH)) u_array (
    .clk(clk), .we(wr_go), .addr(addr_q), .wdata(data_q), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      data_q    <= '0;
      ie_q      <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      rd_pend_q <= rd_go;
      if (io_we && io_addr == 2'(REG_ADDR_LO)) addr_q[7:0] <= io_wdata;
      if (io_we && io_addr == 2'(REG_ADDR_HI)) addr_q[AW-1:8] <= io_wdata[HI_W-1:0];
      if (ctrl_wr) ie_q <= io_wdata[CB_IE];
      if (rd_pend_q) data_q <= mem_q;
      else if (io_we && io_addr == 2'(REG_DATA)) data_q <= io_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) io_rdata <= '0;
    else if (io_re) begin
      case (io_addr)
        2'(REG_ADDR_LO): io_rdata <= addr_q[7:0];
        2'(REG_ADDR_HI): io_rdata <= 8'(addr_q[AW-1:8]);
        2'(REG_DATA):    io_rdata <= data_q;
        default: begin
          io_rdata          <= '0;
          io_rdata[CB_ARM]  <= arm_active;
          io_rdata[CB_IE]   <= ie_q;
          io_rdata[CB_BUSY] <= busy;
        end
      endcase
    end
  end

  assign cpu_stall = stall_active;
  assign rdy_irq   = ie_q && !busy;
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk #(
  parameter int SW       = 3,
  parameter int BW       = 5,
  parameter int RD_STALL = 4,
  parameter int WR_STALL = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ctrl_wr,
  input logic          wr_bit,
  input logic          rd_bit,
  input logic          busy,
  input logic          arm_active,
  input logic          cpu_stall,
  input logic          rdy_irq,
  input logic [SW-1:0] stall_cnt,
  input logic [BW-1:0] busy_cnt
);
  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  AST_READ_STALL: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && rd_bit && !wr_bit && !busy) |=> (cpu_stall && stall_cnt == SW'(RD_STALL))); // R3

  AST_WRITE_STALL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (stall_cnt == SW'(WR_STALL))); // R4

  AST_WRITE_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(arm_active)); // R5

  AST_UNARMED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wr_bit && !arm_active && !busy) |=> !busy); // R6

  AST_BUSY_NOT_EXTENDED: assert property (@(posedge clk) disable iff (rst)
    (busy && ctrl_wr && wr_bit) |=> (busy_cnt == BW'($past(busy_cnt) - 1'b1))); // R8

  AST_IRQ_QUIET_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rdy_irq); // R9

  AST_RESET_IDLE: assert property (@(posedge clk)
    (seen && $past(rst)) |-> (!busy && !cpu_stall && !arm_active)); // R10
endmodule

bind nvm_ctrl nvm_ctrl_chk #(
  .SW(SW), .BW(BW), .RD_STALL(RD_STALL), .WR_STALL(WR_STALL)
) u_chk (
  .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr),
  .wr_bit(io_wdata[nvm_pkg::CB_WR]), .rd_bit(io_wdata[nvm_pkg::CB_RD]),
  .busy(busy), .arm_active(arm_active), .cpu_stall(cpu_stall),
  .rdy_irq(rdy_irq), .stall_cnt(stall_cnt), .busy_cnt(busy_cnt)
);

// File: tb/nvm_ctrl_bench.sv
module nvm_ctrl_bench;
  localparam int WR_CYC = 16;
  localparam logic [7:0] C_RD = 8'h01, C_WR = 8'h02, C_ARM = 8'h04,
                         C_IE = 8'h08, C_BUSY = 8'h10;
  localparam int NV = 6;
  localparam logic [16:0] VEC [NV] = '{
    {9'h000, 8'h5A}, {9'h1FF, 8'hA5}, {9'h100, 8'h3C},
    {9'h0FF, 8'hC3}, {9'h155, 8'h00}, {9'h0AA, 8'hFF}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic io_we = 1'b0, io_re = 1'b0;
  logic [1:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic cpu_stall, rdy_irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nvm_ctrl #(.DEPTH(512), .WR_CYCLES(WR_CYC), .RD_STALL(4), .WR_STALL(2), .ARM_WIN(4))
  u_nvm_ctrl (.clk(clk), .rst(rst), .io_we(io_we), .io_re(io_re), .io_addr(io_addr),
              .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_stall(cpu_stall),
              .rdy_irq(rdy_irq));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic io_wr(input logic [1:0] a, input logic [7:0] d);
    io_we = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic io_rd(input logic [1:0] a, output logic [7:0] d);
    io_re = 1'b1; io_addr = a;
    @(negedge clk);
    io_re = 1'b0;
    d = io_rdata;
  endtask

  task automatic set_addr(input logic [8:0] a);
    io_wr(2'd0, a[7:0]);
    io_wr(2'd1, {7'd0, a[8]});
  endtask

  task automatic wait_idle();
    while (!rdy_irq) @(negedge clk);
  endtask

  // arm then strobe immediately; returns busy and stall cycle counts
  task automatic do_write(input logic [8:0] a, input logic [7:0] d,
                          output int nbusy, output int nstall);
    set_addr(a);
    io_wr(2'd2, d);
    io_wr(2'd3, C_ARM | C_IE);
    io_wr(2'd3, C_WR | C_IE);
    nbusy = 0; nstall = 0;
    while (!rdy_irq && nbusy < 1000) begin
      nbusy++;
      if (cpu_stall) nstall++;
      @(negedge clk);
    end
  endtask

  task automatic do_read(input logic [8:0] a, output logic [7:0] d, output int nstall);
    set_addr(a);
    io_wr(2'd3, C_RD | C_IE);
    nstall = 0;
    while (cpu_stall && nstall < 100) begin
      nstall++;
      @(negedge clk);
    end
    io_rd(2'd2, d);
  endtask

  initial begin
    logic [7:0] rd;
    int nb, ns;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10 stall after reset", int'(cpu_stall), 0);
    check("R9 irq after reset", int'(rdy_irq), 0);
    io_rd(2'd3, rd); check("R10 ctrl after reset", rd, 0);
    io_rd(2'd0, rd); check("R10 addr lo after reset", rd, 0);

    // R1: address registers read back
    set_addr(9'h1A7);
    io_rd(2'd0, rd); check("R1 addr lo readback", rd, 8'hA7);
    io_rd(2'd1, rd); check("R1 addr hi readback", rd, 8'h01);

    // table walk: writes
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][16:8], VEC[i][7:0], nb, ns);
      check("R7 busy length", nb, WR_CYC);
      check("R4 write stall", ns, 2);
    end
    // table walk: reads
    for (int i = 0; i < NV; i++) begin
      do_read(VEC[i][16:8], rd, ns);
      check("R3 read stall", ns, 4);
      check("R2 R1 read data", rd, VEC[i][7:0]);
    end

    // R5: arm bit visible, then self-clears
    io_wr(2'd3, C_ARM | C_IE);
    io_rd(2'd3, rd); check("R5 arm visible", int'(rd[2]), 1);
    repeat (5) @(negedge clk);
    io_rd(2'd3, rd); check("R5 arm self clear", int'(rd[2]), 0);

    // R6: strobe on fifth edge after arm ignored
    set_addr(9'h0AA);
    io_wr(2'd2, 8'h77);
    io_wr(2'd3, C_ARM | C_IE);
    repeat (4) @(negedge clk);
    io_wr(2'd3, C_WR | C_IE);
    check("R6 late strobe no busy", int'(rdy_irq), 1);
    check("R6 late strobe no stall", int'(cpu_stall), 0);
    // R6: strobe with no arm at all
    io_wr(2'd3, C_WR | C_IE);
    check("R6 unarmed no busy", int'(rdy_irq), 1);
    do_read(9'h0AA, rd, ns);
    check("R6 array unchanged", rd, 8'hFF);

    // R5: strobe on fourth edge accepted; R11 window consumed
    set_addr(9'h0AA);
    io_wr(2'd2, 8'h66);
    io_wr(2'd3, C_ARM | C_IE);
    repeat (3) @(negedge clk);
    io_wr(2'd3, C_WR | C_IE);
    check("R5 last edge accepted", int'(rdy_irq), 0);
    io_rd(2'd3, rd);
    check("R11 arm consumed", int'(rd[2]), 0);
    check("R7 busy bit", int'(rd[4]), 1);
    // R8: while busy, read and write strobes ignored
    set_addr(9'h100);
    io_wr(2'd3, C_RD | C_IE);
    check("R8 read while busy no stall", int'(cpu_stall), 0);
    io_rd(2'd2, rd); check("R8 data reg stable", rd, 8'h66);
    io_wr(2'd2, 8'h99);
    io_wr(2'd3, C_ARM | C_IE);
    io_wr(2'd3, C_WR | C_IE);
    wait_idle();
    do_read(9'h100, rd, ns); check("R8 write while busy ignored", rd, 8'h3C);
    do_read(9'h0AA, rd, ns); check("R7 accepted write stored", rd, 8'h66);

    // R9: irq follows enable
    io_wr(2'd3, 8'h00);
    check("R9 irq off when disabled", int'(rdy_irq), 0);
    io_wr(2'd3, C_IE);
    check("R9 irq on when idle", int'(rdy_irq), 1);

    // R10: reset keeps array, clears address
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    io_rd(2'd1, rd); check("R10 addr hi cleared", rd, 0);
    io_rd(2'd3, rd); check("R10 ctrl cleared", int'(rd & (C_IE | C_BUSY | C_ARM)), 0);
    do_read(9'h1FF, rd, ns); check("R10 array kept", rd, 8'hA5);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule